// File: doc/BRIEF.md
# Binary Accumulator ALU with Processor Status Update

This block carries out the accumulator-group arithmetic, logic, shift and flag operations of an 8-bit 6502-class processor core, always in binary. Each cycle it takes an operation code, a register operand (the accumulator, or X/Y for compares, or the value being shifted, incremented or decremented), a memory operand and the current processor status byte. It returns the data result and the updated status byte. Operand fetch, write-back and decimal arithmetic belong to the surrounding core.

The status byte uses this layout: bit 7 negative (N), bit 6 overflow (V), bit 5 and bit 4 unused by this block, bit 3 decimal (D), bit 2 interrupt mask (I), bit 1 zero (Z), bit 0 carry (C). Carry and overflow follow the processor's exact rules: subtraction takes carry as an inverted borrow, compare sets carry when no borrow occurs, and overflow comes from the sign bits of the operands and the result. With the default parameters both outputs are registered, so a result appears one clock after its operands.

Top module: `alu65_core`

## Requirements
- R1: While rst_n is low, result and stat_out are both 0x00. With the default configuration, the outputs after a rising clock edge reflect the inputs sampled at that edge.
- R2: Operation codes 0, 1 and 2 produce reg_opnd OR, AND and XOR mem_opnd. N (bit 7) takes result bit 7, Z (bit 1) is set when the result is zero, and every other status bit is copied from stat_in.
- R3: Operation code 3 adds reg_opnd, mem_opnd and stat_in C (bit 0). C is set when the 9-bit sum exceeds 255, and V (bit 6) is set when both operands share a sign that the result does not. N and Z follow the result.
- R4: Operation code 5 produces reg_opnd - mem_opnd - (1 - C). C is set when that difference is not negative, and V is set when the signed difference lies outside -128..127. N and Z follow the result.
- R5: Operation code 4 compares: result returns reg_opnd unchanged. N and Z follow the low byte of reg_opnd - mem_opnd, C is set when reg_opnd >= mem_opnd (unsigned), and V is held.
- R6: Operation codes 6 (shift left) and 8 (shift right) shift reg_opnd with a zero filled in. The bit shifted out goes to C, N and Z follow the result, and V is held.
- R7: Operation codes 7 (rotate left) and 9 (rotate right) work like R6, except that the old C fills the vacated bit (bit 0 on the left rotate, bit 7 on the right rotate).
- R8: Operation codes 10 and 11 return reg_opnd plus one and minus one, wrapping modulo 256. N and Z follow the result, and C and V are held.
- R9: Operation code 12 tests bits. N takes mem_opnd bit 7, V takes mem_opnd bit 6, Z is set when reg_opnd AND mem_opnd is zero, the other bits are held, and result returns reg_opnd.
- R10: Operation code 13 sets or clears one flag chosen by flag_sel: 0 clears C, 1 sets C, 2 clears I, 3 sets I, 4 changes nothing, 5 clears V, 6 clears D, 7 sets D. Result returns reg_opnd.
- R11: Status bits 5 and 4 always pass through from stat_in. D and I change only under operation code 13. A set D flag never changes an arithmetic result.
- R12: Operation codes 14 and 15 return reg_opnd and stat_in unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (see R2 to R12) |
| reg_opnd | input | 8 | Register operand |
| mem_opnd | input | 8 | Memory operand |
| stat_in | input | 8 | Current processor status byte |
| flag_sel | input | 3 | Flag selector for operation code 13 |
| result | output | 8 | Data result |
| stat_out | output | 8 | Updated processor status byte |

## Verification
The properties check every cycle that the unused status bits pass through, that D and I move only under the flag operation, that compare, logic, shift and increment operations keep the flags they must not touch, and that the pass-through codes return their inputs. Whether the values are correct cannot be seen from those invariants. The bench's scenarios alone show the sums and differences themselves, the carry and overflow boundaries (signed overflow in both directions, borrow with and without incoming carry, wrap from 0xFF to 0x00) and the rotate fill bits. They are compared against a reference model in the bench written in signed and unsigned integers.

// File: rtl/alu65_pkg.sv
package alu65_pkg;

   typedef enum logic [3:0] {
      OP_ORA  = 4'd0,
      OP_AND  = 4'd1,
      OP_EOR  = 4'd2,
      OP_ADC  = 4'd3,
      OP_CMP  = 4'd4,
      OP_SBC  = 4'd5,
      OP_ASL  = 4'd6,
      OP_ROL  = 4'd7,
      OP_LSR  = 4'd8,
      OP_ROR  = 4'd9,
      OP_INC  = 4'd10,
      OP_DEC  = 4'd11,
      OP_BIT  = 4'd12,
      OP_FLAG = 4'd13,
      OP_PASS = 4'd14,
      OP_PAS2 = 4'd15
   } alu_op_e;

   localparam int ST_N = 7;
   localparam int ST_V = 6;
   localparam int ST_D = 3;
   localparam int ST_I = 2;
   localparam int ST_Z = 1;
   localparam int ST_C = 0;
   localparam int ST_W = 8;

   // Per-unit flag request: a write-enable and a value for each arithmetic flag
   typedef struct packed {
      logic wr_n;
      logic wr_v;
      logic wr_z;
      logic wr_c;
      logic n;
      logic v;
      logic z;
      logic c;
   } flag_upd_t;

   localparam flag_upd_t FLAG_NONE = '0;

   function automatic logic [ST_W-1:0] apply_upd(input logic [ST_W-1:0] s,
                                                 input flag_upd_t        u);
      logic [ST_W-1:0] r;
      r = s;
      if (u.wr_n) r[ST_N] = u.n;
      if (u.wr_v) r[ST_V] = u.v;
      if (u.wr_z) r[ST_Z] = u.z;
      if (u.wr_c) r[ST_C] = u.c;
      return r;
   endfunction

   function automatic logic is_logic_op(input alu_op_e o);
      return (o == OP_ORA) || (o == OP_AND) || (o == OP_EOR) || (o == OP_BIT);
   endfunction

   function automatic logic is_arith_op(input alu_op_e o);
      return (o == OP_ADC) || (o == OP_SBC) || (o == OP_CMP) ||
             (o == OP_INC) || (o == OP_DEC);
   endfunction

   function automatic logic is_shift_op(input alu_op_e o);
      return (o == OP_ASL) || (o == OP_ROL) || (o == OP_LSR) || (o == OP_ROR);
   endfunction

endpackage

// File: rtl/alu65_logic_unit.sv
module alu65_logic_unit
   import alu65_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] m,
   output logic [DATA_W-1:0] res,
   output flag_upd_t         upd
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] and_v;
   assign and_v = a & m;

   always_comb begin
      res = a;
      upd = FLAG_NONE;
      case (op)
         OP_ORA: res = a | m;
         OP_AND: res = and_v;
         OP_EOR: res = a ^ m;
         default: res = a;
      endcase
      if (op == OP_BIT) begin
         upd.wr_n = 1'b1;
         upd.wr_v = 1'b1;
         upd.wr_z = 1'b1;
         upd.n    = m[MSB];
         upd.v    = m[MSB-1];
         upd.z    = ~|and_v;
      end else begin
         upd.wr_n = 1'b1;
         upd.wr_z = 1'b1;
         upd.n    = res[MSB];
         upd.z    = ~|res;
      end
   end

endmodule

// File: rtl/alu65_addsub_unit.sv
module alu65_addsub_unit
   import alu65_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] m,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output flag_upd_t         upd
);
   localparam int MSB = DATA_W - 1;
   localparam int SUM_W = DATA_W + 1;

   logic [DATA_W-1:0] b_opnd;
   logic              cy_in;
   logic [SUM_W-1:0]  sum;
   logic              ovf;

   // One adder serves add, subtract, compare, increment and decrement
   always_comb begin
      b_opnd = '0;
      cy_in  = 1'b0;
      case (op)
         OP_ADC: begin b_opnd = m;          cy_in = c_in; end
         OP_SBC: begin b_opnd = ~m;         cy_in = c_in; end
         OP_CMP: begin b_opnd = ~m;         cy_in = 1'b1; end
         OP_INC: begin b_opnd = '0;         cy_in = 1'b1; end
         OP_DEC: begin b_opnd = {DATA_W{1'b1}}; cy_in = 1'b0; end
         default: begin b_opnd = '0;        cy_in = 1'b0; end
      endcase
   end

   assign sum = {1'b0, a} + {1'b0, b_opnd} + {{DATA_W{1'b0}}, cy_in};
   assign res = sum[DATA_W-1:0];
   // Same-sign operands whose sign the result does not keep
   assign ovf = (~(a[MSB] ^ b_opnd[MSB])) & (a[MSB] ^ res[MSB]);

   always_comb begin
      upd      = FLAG_NONE;
      upd.n    = res[MSB];
      upd.z    = ~|res;
      upd.c    = sum[DATA_W];
      upd.v    = ovf;
      case (op)
         OP_ADC, OP_SBC: begin
            upd.wr_n = 1'b1; upd.wr_z = 1'b1; upd.wr_c = 1'b1; upd.wr_v = 1'b1;
         end
         OP_CMP: begin
            upd.wr_n = 1'b1; upd.wr_z = 1'b1; upd.wr_c = 1'b1;
         end
         OP_INC, OP_DEC: begin
            upd.wr_n = 1'b1; upd.wr_z = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu65_shift_unit.sv
module alu65_shift_unit
   import alu65_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output flag_upd_t         upd
);
   localparam int MSB = DATA_W - 1;

   logic fill;
   logic to_left;

   assign to_left = (op == OP_ASL) || (op == OP_ROL);
   assign fill    = ((op == OP_ROL) || (op == OP_ROR)) ? c_in : 1'b0;

   always_comb begin
      upd      = FLAG_NONE;
      if (to_left) begin
         res   = {a[MSB-1:0], fill};
         upd.c = a[MSB];
      end else begin
         res   = {fill, a[MSB:1]};
         upd.c = a[0];
      end
      upd.wr_c = 1'b1;
      upd.wr_n = 1'b1;
      upd.wr_z = 1'b1;
      upd.n    = res[MSB];
      upd.z    = ~|res;
   end

endmodule

// File: rtl/alu65_flag_unit.sv
module alu65_flag_unit
   import alu65_pkg::*;
(
   input  logic [2:0]      sel,
   input  logic [ST_W-1:0] s_in,
   output logic [ST_W-1:0] s_out
);
   // Selector values follow the top three opcode bits of the flag instructions
   always_comb begin
      s_out = s_in;
      case (sel)
         3'd0: s_out[ST_C] = 1'b0;
         3'd1: s_out[ST_C] = 1'b1;
         3'd2: s_out[ST_I] = 1'b0;
         3'd3: s_out[ST_I] = 1'b1;
         3'd5: s_out[ST_V] = 1'b0;
         3'd6: s_out[ST_D] = 1'b0;
         3'd7: s_out[ST_D] = 1'b1;
         default: s_out = s_in;
      endcase
   end

endmodule

// File: rtl/alu65_core.sv
module alu65_core
   import alu65_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] reg_opnd,
   input  logic [DATA_W-1:0] mem_opnd,
   input  logic [ST_W-1:0]   stat_in,
   input  logic [2:0]        flag_sel,
   output logic [DATA_W-1:0] result,
   output logic [ST_W-1:0]   stat_out
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("alu65_core: DATA_W must be at least 2");
      end
   endgenerate

   alu_op_e           op_e;
   logic [DATA_W-1:0] lg_res, as_res, sh_res;
   flag_upd_t         lg_upd, as_upd, sh_upd;
   logic [ST_W-1:0]   fl_stat;
   logic [DATA_W-1:0] res_nxt;
   logic [ST_W-1:0]   st_nxt;

   assign op_e = alu_op_e'(op);

   alu65_logic_unit #(.DATA_W(DATA_W)) logic_i (
      .op (op_e), .a (reg_opnd), .m (mem_opnd), .res (lg_res), .upd (lg_upd)
   );

   alu65_addsub_unit #(.DATA_W(DATA_W)) addsub_i (
      .op (op_e), .a (reg_opnd), .m (mem_opnd), .c_in (stat_in[ST_C]),
      .res (as_res), .upd (as_upd)
   );

   alu65_shift_unit #(.DATA_W(DATA_W)) shift_i (
      .op (op_e), .a (reg_opnd), .c_in (stat_in[ST_C]), .res (sh_res), .upd (sh_upd)
   );

   alu65_flag_unit flag_i (
      .sel (flag_sel), .s_in (stat_in), .s_out (fl_stat)
   );

   // Result and status selection by operation group
   always_comb begin
      res_nxt = reg_opnd;
      st_nxt  = stat_in;
      if (is_logic_op(op_e)) begin
         res_nxt = lg_res;
         st_nxt  = apply_upd(stat_in, lg_upd);
      end else if (is_arith_op(op_e)) begin
         res_nxt = (op_e == OP_CMP) ? reg_opnd : as_res;
         st_nxt  = apply_upd(stat_in, as_upd);
      end else if (is_shift_op(op_e)) begin
         res_nxt = sh_res;
         st_nxt  = apply_upd(stat_in, sh_upd);
      end else if (op_e == OP_FLAG) begin
         st_nxt  = fl_stat;
      end
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic primed;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result   <= '0;
               stat_out <= '0;
               primed   <= 1'b0;
            end else begin
               result   <= res_nxt;
               stat_out <= st_nxt;
               primed   <= 1'b1;
            end
         end

         AST_RSVD_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> stat_out[5:4] == $past(stat_in[5:4]))
            else $error("unused status bits altered"); // R11

         AST_DI_ONLY_BY_FLAG_OP: assert property (@(posedge clk) disable iff (!rst_n)
            primed && ($past(op) != 4'd13) |->
               (stat_out[ST_D] == $past(stat_in[ST_D])) &&
               (stat_out[ST_I] == $past(stat_in[ST_I])))
            else $error("D or I changed outside flag operation"); // R11

         AST_CMP_KEEPS_V_AND_REG: assert property (@(posedge clk) disable iff (!rst_n)
            primed && ($past(op) == 4'd4) |->
               (stat_out[ST_V] == $past(stat_in[ST_V])) && (result == $past(reg_opnd)))
            else $error("compare altered V or result"); // R5

         AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
            primed && ($past(op) <= 4'd2) |->
               (stat_out[ST_C] == $past(stat_in[ST_C])) &&
               (stat_out[ST_V] == $past(stat_in[ST_V])))
            else $error("logic operation altered C or V"); // R2

         AST_SHIFT_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
            primed && ($past(op) >= 4'd6) && ($past(op) <= 4'd9) |->
               stat_out[ST_V] == $past(stat_in[ST_V]))
            else $error("shift altered V"); // R6

         AST_INCDEC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
            primed && (($past(op) == 4'd10) || ($past(op) == 4'd11)) |->
               (stat_out[ST_C] == $past(stat_in[ST_C])) &&
               (stat_out[ST_V] == $past(stat_in[ST_V])))
            else $error("increment or decrement altered C or V"); // R8

         AST_PASS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
            primed && ($past(op) >= 4'd14) |->
               (result == $past(reg_opnd)) && (stat_out == $past(stat_in)))
            else $error("pass-through code altered outputs"); // R12
      end else begin : g_comb_out
         assign result   = res_nxt;
         assign stat_out = st_nxt;
      end
   endgenerate

endmodule

// File: tb/alu65_core_tb.sv
`timescale 1ns/1ps
module alu65_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] reg_opnd = '0, mem_opnd = '0, stat_in = '0;
   logic [2:0] flag_sel = '0;
   logic [7:0] result, stat_out;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   typedef struct {
      logic [7:0] r;
      logic [7:0] s;
      int         due;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   alu65_core dut_i (
      .clk (clk), .rst_n (rst_n), .op (op), .reg_opnd (reg_opnd),
      .mem_opnd (mem_opnd), .stat_in (stat_in), .flag_sel (flag_sel),
      .result (result), .stat_out (stat_out)
   );

   // Reference model written from the requirements in integer arithmetic
   function automatic void model(input logic [3:0] o, input logic [7:0] a, m, s,
                                 input logic [2:0] sel, output logic [7:0] r,
                                 output logic [7:0] st, output string tag);
      int x, sv, c;
      bit nz;
      c  = int'(s[0]);
      r  = a;
      st = s;
      nz = 1;
      x  = 0;
      case (o)
         4'd0: begin r = a | m; tag = "R2"; end
         4'd1: begin r = a & m; tag = "R2"; end
         4'd2: begin r = a ^ m; tag = "R2"; end
         4'd3: begin
            x = int'(a) + int'(m) + c; r = x[7:0]; st[0] = (x > 255);
            sv = int'($signed(a)) + int'($signed(m)) + c;
            st[6] = (sv > 127) || (sv < -128); tag = "R3";
         end
         4'd5: begin
            x = int'(a) - int'(m) - (1 - c); r = x[7:0]; st[0] = (x >= 0);
            sv = int'($signed(a)) - int'($signed(m)) - (1 - c);
            st[6] = (sv > 127) || (sv < -128); tag = "R4";
         end
         4'd4: begin
            x = int'(a) - int'(m); st[0] = (a >= m);
            st[7] = x[7]; st[1] = (x[7:0] == 8'h00); nz = 0; tag = "R5";
         end
         4'd6: begin st[0] = a[7]; r = {a[6:0], 1'b0}; tag = "R6"; end
         4'd8: begin st[0] = a[0]; r = {1'b0, a[7:1]}; tag = "R6"; end
         4'd7: begin st[0] = a[7]; r = {a[6:0], s[0]}; tag = "R7"; end
         4'd9: begin st[0] = a[0]; r = {s[0], a[7:1]}; tag = "R7"; end
         4'd10: begin r = a + 8'd1; tag = "R8"; end
         4'd11: begin r = a - 8'd1; tag = "R8"; end
         4'd12: begin
            st[7] = m[7]; st[6] = m[6]; st[1] = ((a & m) == 8'h00); nz = 0; tag = "R9";
         end
         4'd13: begin
            nz = 0; tag = "R10";
            case (sel)
               3'd0: st[0] = 1'b0;
               3'd1: st[0] = 1'b1;
               3'd2: st[2] = 1'b0;
               3'd3: st[2] = 1'b1;
               3'd5: st[6] = 1'b0;
               3'd6: st[3] = 1'b0;
               3'd7: st[3] = 1'b1;
               default: ;
            endcase
         end
         default: begin nz = 0; tag = "R12"; end
      endcase
      if (nz) begin
         st[7] = r[7];
         st[1] = (r == 8'h00);
      end
   endfunction

   // Driver: applies one operation and queues its expectation
   task automatic drive(input logic [3:0] o, input logic [7:0] a, m, s,
                        input logic [2:0] sel);
      exp_t e;
      @(negedge clk);
      op = o; reg_opnd = a; mem_opnd = m; stat_in = s; flag_sel = sel;
      model(o, a, m, s, sel, e.r, e.s, e.tag);
      e.due = cyc + 1;
      sb_q.push_back(e);
   endtask

   // Monitor: compares each expectation once its capturing edge has passed
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            checks++;
            if (result !== sb_q[0].r || stat_out !== sb_q[0].s) begin
               fails++;
               $display("FAIL %s (status bits per R11): result=%02h status=%02h expected result=%02h status=%02h",
                        sb_q[0].tag, result, stat_out, sb_q[0].r, sb_q[0].s);
            end
            void'(sb_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (result !== 8'h00 || stat_out !== 8'h00) begin
         fails++;
         $display("FAIL R1: result=%02h status=%02h expected result=00 status=00", result, stat_out);
      end
      rst_n = 1'b1;

      // R2 logic group
      drive(4'd0, 8'h0F, 8'hF0, 8'h41, 3'd0);
      drive(4'd1, 8'hAA, 8'h55, 8'hC1, 3'd0);
      drive(4'd2, 8'h3C, 8'h3C, 8'h00, 3'd0);
      // R3 add: signed overflow, carry-out to zero, carry-in into overflow
      drive(4'd3, 8'h50, 8'h50, 8'h00, 3'd0);
      drive(4'd3, 8'hFF, 8'h01, 8'h00, 3'd0);
      drive(4'd3, 8'h7F, 8'h00, 8'h01, 3'd0);
      drive(4'd3, 8'h80, 8'hFF, 8'h00, 3'd0);
      // R11: D set, addition stays binary; bits 5 and 4 carried along
      drive(4'd3, 8'h09, 8'h01, 8'h38, 3'd0);
      // R4 subtract with and without borrow
      drive(4'd5, 8'h50, 8'hB0, 8'h01, 3'd0);
      drive(4'd5, 8'h05, 8'h05, 8'h00, 3'd0);
      drive(4'd5, 8'h05, 8'h05, 8'h01, 3'd0);
      drive(4'd5, 8'h80, 8'h01, 8'h01, 3'd0);
      // R5 compare: equal, below, above, V held
      drive(4'd4, 8'h42, 8'h42, 8'h40, 3'd0);
      drive(4'd4, 8'h10, 8'h20, 8'h41, 3'd0);
      drive(4'd4, 8'hF0, 8'h01, 8'h00, 3'd0);
      // R6 and R7 shifts and rotates
      drive(4'd6, 8'h81, 8'h00, 8'h00, 3'd0);
      drive(4'd8, 8'h01, 8'h00, 8'h40, 3'd0);
      drive(4'd7, 8'h80, 8'h00, 8'h01, 3'd0);
      drive(4'd9, 8'h02, 8'h00, 8'h01, 3'd0);
      drive(4'd7, 8'h40, 8'h00, 8'h00, 3'd0);
      // R8 wrap at both ends
      drive(4'd10, 8'hFF, 8'h00, 8'h41, 3'd0);
      drive(4'd11, 8'h00, 8'h00, 8'h00, 3'd0);
      // R9 bit test
      drive(4'd12, 8'h0F, 8'hC0, 8'h01, 3'd0);
      drive(4'd12, 8'h01, 8'h3F, 8'hC2, 3'd0);
      // R10 every selector value
      for (int k = 0; k < 8; k++) drive(4'd13, 8'h5A, 8'h00, 8'h00, 3'(k));
      for (int k = 0; k < 8; k++) drive(4'd13, 8'h5A, 8'h00, 8'hFF, 3'(k));
      // R12 pass-through codes
      drive(4'd14, 8'h33, 8'hCC, 8'hA5, 3'd3);
      drive(4'd15, 8'h00, 8'hFF, 8'h5A, 3'd7);
      // Mixed patterns over all codes
      for (int i = 0; i < 400; i++)
         drive(4'($urandom % 16), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom));
      repeat (4) @(negedge clk);
      done = 1;
      if (sb_q.size() != 0) begin
         fails++;
         $display("FAIL R1: pending expectations=%0d expected=0", sb_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule